// File: doc/BRIEF.md
# Adaptive Gain Two-Microphone Beamformer

This block is a streaming fixed-point beamformer for a pair of closely spaced omnidirectional microphones. Every accepted sample pair forms two differential cardioids. The forward beam is the front signal minus the rear signal delayed by the acoustic travel time between the microphones. The backward beam is the rear signal minus the front signal delayed by the same time. The output sample is the forward beam minus a scalar gain times the backward beam.

The gain adapts once per frame of 64 samples. Over each frame the block sums the product of the two beams, and separately the square of the backward beam. Each sum is normalised by the frame length and blended half-and-half with the previous estimate. At the end of the frame the block sends the two smoothed estimates to an external divider as one request. It loads the returned quotient as the new gain. Until that quotient arrives, the previous gain stays in force.

Top module: `adaptive_gain_bf`

## Requirements
- R1: After a synchronous reset, `out_valid` and `div_req_valid` are low, `out_y` is 0, the gain is 0, both delay lines and both smoothed estimates hold 0, and the frame counter starts a new frame.
- R2: With D = `DLY` accepted samples of delay, the forward beam is c1(n) = front(n) − rear(n−D) and the backward beam is c2(n) = rear(n) − front(n−D). Each is DW+1 bits wide, and samples before the first accepted one count as 0.
- R3: For a sample accepted on clock edge k, `out_valid` is high for exactly the one cycle after edge k+1. That cycle carries `out_y` = sat(c1 − ((W·c2 + 2^(GF−1)) >>> GF)), where W is the gain register value before edge k+1 and is a signed GW-bit value with GF fraction bits.
- R4: `out_y` saturates to the signed DW-bit range, [−2^(DW−1), 2^(DW−1)−1].
- R5: The 64th accepted sample of each frame closes the frame. With S12 = Σc1·c2 and S22 = Σc2² over the frame, the estimates become E12 ← (S12 >>> 7) + (E12 >>> 1) and E22 ← (S22 >>> 7) + (E22 >>> 1), using arithmetic shifts.
- R6: If the last sample of a frame is accepted on edge k and the new E22 is nonzero, `div_req_valid` is high for exactly the one cycle after edge k+2. In that cycle `div_num` = E12 and `div_den` = E22.
- R7: If the new E22 is zero, no request is issued and the gain is unchanged.
- R8: The gain changes only on an edge where `div_rsp_valid` is high, and then takes `div_quot`, a signed GW-bit value with GF fraction bits. Samples whose output is formed before that edge use the previous gain.
- R9: When `in_valid` is low, `in_front` and `in_rear` are ignored: the delay lines, the sums and the output do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample pair present this cycle |
| in_front | input | DW | Front microphone sample, signed |
| in_rear | input | DW | Rear microphone sample, signed |
| out_valid | output | 1 | Output sample present |
| out_y | output | DW | Beamformed output sample, signed |
| div_req_valid | output | 1 | One-cycle divide request |
| div_num | output | 2*(DW+1)+FRAME_LOG2 | Dividend: smoothed cross estimate |
| div_den | output | 2*(DW+1)+FRAME_LOG2 | Divisor: smoothed backward power |
| div_rsp_valid | input | 1 | Quotient present |
| div_quot | input | GW | New gain, GF fraction bits |

## Verification
An output sample is due two edges after its input edge, and a divide request one edge later still. The bench gives each sample four falling-edge slots. It drives the input in the first slot and fills the second with random values while `in_valid` is low. It checks `out_y` in the third slot and the request lines in the fourth. Divider responses are sent only between samples, either at once or three samples late. This makes the gain in force for every expected output exact.

// File: rtl/bf_pkg.sv
package bf_pkg;
  localparam int XW = 96;

  function automatic logic signed [XW-1:0] rshift_round(input logic signed [XW-1:0] x,
                                                        input int unsigned s);
    logic signed [XW-1:0] half;
    half = '0;
    half[s-1] = 1'b1;
    return (x + half) >>> s;
  endfunction

  function automatic logic signed [XW-1:0] sat_to(input logic signed [XW-1:0] x,
                                                  input int unsigned w);
    logic signed [XW-1:0] hi;
    logic signed [XW-1:0] lo;
    hi = '0;
    hi[w-1] = 1'b1;
    hi = hi - 1;
    lo = -hi - 1;
    if (x > hi) return hi;
    if (x < lo) return lo;
    return x;
  endfunction
endpackage

// File: rtl/bf_delay.sv
module bf_delay #(
  parameter int W   = 24,
  parameter int DLY = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] taps [DLY];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DLY; i++) taps[i] <= '0;
    end else if (en) begin
      taps[0] <= din;
      for (int i = 1; i < DLY; i++) taps[i] <= taps[i-1];
    end
  end

  assign dout = taps[DLY-1];
endmodule

// File: rtl/bf_corr.sv
module bf_corr #(
  parameter int CW         = 25,
  parameter int FRAME_LOG2 = 6,
  localparam int PW        = 2 * CW,
  localparam int ACCW      = PW + FRAME_LOG2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic                   last,
  input  logic signed [CW-1:0]   a,
  input  logic signed [CW-1:0]   b,
  output logic signed [ACCW-1:0] est
);
  logic signed [PW-1:0]   prod;
  logic signed [ACCW-1:0] acc;
  logic signed [ACCW-1:0] sum;

  assign prod = a * b;
  assign sum  = acc + {{FRAME_LOG2{prod[PW-1]}}, prod};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      est <= '0;
    end else if (en) begin
      if (last) begin
        acc <= '0;
        est <= (sum >>> (FRAME_LOG2 + 1)) + (est >>> 1);
      end else begin
        acc <= sum;
      end
    end
  end
endmodule

// File: rtl/adaptive_gain_bf.sv
module adaptive_gain_bf #(
  parameter int DW         = 24,
  parameter int GW         = 24,
  parameter int GF         = 16,
  parameter int DLY        = 2,
  parameter int FRAME_LOG2 = 6,
  localparam int CW        = DW + 1,
  localparam int ACCW      = 2 * CW + FRAME_LOG2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [DW-1:0]   in_front,
  input  logic [DW-1:0]   in_rear,
  output logic            out_valid,
  output logic [DW-1:0]   out_y,
  output logic            div_req_valid,
  output logic [ACCW-1:0] div_num,
  output logic [ACCW-1:0] div_den,
  input  logic            div_rsp_valid,
  input  logic [GW-1:0]   div_quot
);
  import bf_pkg::*;

  localparam int MW = GW + CW;

  logic [DW-1:0]          front_d, rear_d;
  logic signed [CW-1:0]   c1_q, c2_q;
  logic                   v1;
  logic signed [GW-1:0]   gain_q;
  logic [FRAME_LOG2-1:0]  cnt;
  logic                   last;
  logic                   frame_end;
  logic signed [ACCW-1:0] e12, e22;
  logic signed [MW-1:0]   prod;
  logic signed [XW-1:0]   prod_x, c1_x, y_x, y_sat;

  bf_delay #(.W(DW), .DLY(DLY)) front_dl_i (
    .clk(clk), .rst(rst), .en(in_valid), .din(in_front), .dout(front_d));
  bf_delay #(.W(DW), .DLY(DLY)) rear_dl_i (
    .clk(clk), .rst(rst), .en(in_valid), .din(in_rear), .dout(rear_d));

  // Beam formation stage
  always_ff @(posedge clk) begin
    if (rst) begin
      c1_q <= '0;
      c2_q <= '0;
      v1   <= 1'b0;
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        c1_q <= $signed({in_front[DW-1], in_front}) - $signed({rear_d[DW-1], rear_d});
        c2_q <= $signed({in_rear[DW-1], in_rear}) - $signed({front_d[DW-1], front_d});
      end
    end
  end

  // Gain application stage
  assign prod   = gain_q * c2_q;
  assign prod_x = {{(XW-MW){prod[MW-1]}}, prod};
  assign c1_x   = {{(XW-CW){c1_q[CW-1]}}, c1_q};
  assign y_x    = c1_x - rshift_round(prod_x, GF);
  assign y_sat  = sat_to(y_x, DW);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_y     <= '0;
    end else begin
      out_valid <= v1;
      if (v1) out_y <= y_sat[DW-1:0];
    end
  end

  // Frame tracking and correlation
  assign last = (cnt == {FRAME_LOG2{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      frame_end <= 1'b0;
    end else begin
      frame_end <= v1 && last;
      if (v1) cnt <= cnt + 1'b1;
    end
  end

  bf_corr #(.CW(CW), .FRAME_LOG2(FRAME_LOG2)) cross_i (
    .clk(clk), .rst(rst), .en(v1), .last(last), .a(c1_q), .b(c2_q), .est(e12));
  bf_corr #(.CW(CW), .FRAME_LOG2(FRAME_LOG2)) power_i (
    .clk(clk), .rst(rst), .en(v1), .last(last), .a(c2_q), .b(c2_q), .est(e22));

  // Divide request and gain update
  always_ff @(posedge clk) begin
    if (rst) begin
      div_req_valid <= 1'b0;
      div_num       <= '0;
      div_den       <= '0;
      gain_q        <= '0;
    end else begin
      div_req_valid <= frame_end && (e22 != '0);
      if (frame_end) begin
        div_num <= e12;
        div_den <= e22;
      end
      if (div_rsp_valid) gain_q <= div_quot;
    end
  end

  // R3
  out_timing_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2));
  // R8
  gain_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(div_rsp_valid) |-> $stable(gain_q));
  // R7
  req_den_chk: assert property (@(posedge clk) disable iff (rst)
    div_req_valid |-> (div_den != '0));
  // R6
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    div_req_valid |=> !div_req_valid);
endmodule

// File: tb/adaptive_gain_bf_tb_top.sv
module adaptive_gain_bf_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 24;
  localparam int GW = 24;
  localparam int GF = 16;
  localparam int DLY = 2;
  localparam int FRAME_LOG2 = 6;
  localparam int M = 1 << FRAME_LOG2;
  localparam int ACCW = 2 * (DW + 1) + FRAME_LOG2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_front = '0, in_rear = '0;
  logic out_valid, div_req_valid;
  logic [DW-1:0] out_y;
  logic [ACCW-1:0] div_num, div_den;
  logic div_rsp_valid = 1'b0;
  logic [GW-1:0] div_quot = '0;

  int total = 0, bad = 0;
  bit done = 0;

  longint fh [DLY];
  longint rh [DLY];
  longint w_m = 0, e12 = 0, e22 = 0, s12 = 0, s22 = 0;
  int cnt = 0, pend = -1, resp_dly = 0;
  longint pend_q = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adaptive_gain_bf #(.DW(DW), .GW(GW), .GF(GF), .DLY(DLY), .FRAME_LOG2(FRAME_LOG2)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_front(in_front), .in_rear(in_rear),
    .out_valid(out_valid), .out_y(out_y), .div_req_valid(div_req_valid),
    .div_num(div_num), .div_den(div_den), .div_rsp_valid(div_rsp_valid), .div_quot(div_quot));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint sat_w(input longint x, input int w);
    longint hi = (longint'(1) <<< (w - 1)) - 1;
    if (x > hi) return hi;
    if (x < -hi - 1) return -hi - 1;
    return x;
  endfunction

  function automatic longint quot_of(input longint num, input longint den);
    logic signed [95:0] n, q, hi;
    n = num;
    n = n <<< GF;
    q = n / den;
    hi = (96'sd1 <<< (GW - 1)) - 1;
    if (q > hi) q = hi;
    if (q < -hi - 1) q = -hi - 1;
    return longint'(q);
  endfunction

  function automatic longint rnd_sample();
    logic signed [DW-1:0] s;
    s = DW'($urandom);
    return longint'(s) >>> ($urandom % 4);
  endfunction

  task automatic deliver();
    div_quot = GW'(pend_q);
    div_rsp_valid = 1'b1;
    @(negedge clk);
    div_rsp_valid = 1'b0;
    div_quot = GW'($urandom);
    w_m = pend_q;
    pend = -1;
  endtask

  task automatic do_sample(input longint f, input longint r, input bit sat_case);
    longint c1, c2, t, y, yraw;
    bit req_exp;
    string tag;
    c1 = f - rh[DLY-1];
    c2 = r - fh[DLY-1];
    for (int i = DLY - 1; i > 0; i--) begin
      fh[i] = fh[i-1];
      rh[i] = rh[i-1];
    end
    fh[0] = f;
    rh[0] = r;
    t = w_m * c2;
    t = (t + (longint'(1) <<< (GF - 1))) >>> GF;
    yraw = c1 - t;
    y = sat_w(yraw, DW);
    if (yraw != y || sat_case) tag = "R4";
    else if (pend > 0) tag = "R8";
    else tag = "R3/R2";

    @(negedge clk);
    in_front = DW'(f);
    in_rear  = DW'(r);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    in_front = DW'($urandom);   // R9: ignored while in_valid is low
    in_rear  = DW'($urandom);
    @(negedge clk);
    chk(out_valid === 1'b1, "R3 out_valid", longint'(out_valid), 1);
    chk(longint'($signed(out_y)) == y, tag, longint'($signed(out_y)), y);
    chk(div_req_valid === 1'b0, "R6 early req", longint'(div_req_valid), 0);

    s12 += c1 * c2;
    s22 += c2 * c2;
    cnt++;
    req_exp = 0;
    if (cnt == M) begin
      e12 = (s12 >>> (FRAME_LOG2 + 1)) + (e12 >>> 1);
      e22 = (s22 >>> (FRAME_LOG2 + 1)) + (e22 >>> 1);
      s12 = 0;
      s22 = 0;
      cnt = 0;
      req_exp = (e22 != 0);
      if (req_exp) begin
        pend_q = quot_of(e12, e22);
        pend = resp_dly;
      end
    end
    @(negedge clk);
    chk(out_valid === 1'b0, "R9 out pulse", longint'(out_valid), 0);
    if (cnt == 0 && !req_exp)
      chk(div_req_valid === 1'b0, "R7 no request", longint'(div_req_valid), 0);
    else
      chk(div_req_valid === req_exp, "R6 request", longint'(div_req_valid), longint'(req_exp));
    if (req_exp) begin
      chk(longint'($signed(div_num)) == e12, "R5 cross estimate", longint'($signed(div_num)), e12);
      chk(longint'($signed(div_den)) == e22, "R5 power estimate", longint'($signed(div_den)), e22);
    end
    if (pend == 0) deliver();
    else if (pend > 0) pend--;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < DLY; i++) begin
      fh[i] = 0;
      rh[i] = 0;
    end
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R1 out_valid", longint'(out_valid), 0);
    chk(div_req_valid === 1'b0, "R1 div_req_valid", longint'(div_req_valid), 0);
    @(negedge clk);
    rst = 1'b0;
    chk(out_y === '0, "R1 out_y", longint'(out_y), 0);

    // Frame 0: rear is the delayed front, so c2 = 0 and no divide (R7), gain 0 (R1)
    for (int n = 0; n < M; n++) begin
      longint f;
      f = rnd_sample();
      do_sample(f, fh[DLY-1], 1'b0);
    end
    chk(pend == -1, "R7 gain held", longint'(pend), -1);

    // Random frames, response delivered at once or three samples late (R8)
    for (int fr = 1; fr < 8; fr++) begin
      resp_dly = (fr % 2 == 0) ? 3 : 0;
      for (int n = 0; n < M; n++) begin
        if (fr == 2 && n >= 10 && n < 16)
          do_sample((longint'(1) <<< (DW - 1)) - 1, -(longint'(1) <<< (DW - 1)), 1'b1);
        else if (fr == 5 && n >= 20 && n < 24)
          do_sample(-(longint'(1) <<< (DW - 1)), (longint'(1) <<< (DW - 1)) - 1, 1'b1);
        else
          do_sample(rnd_sample(), rnd_sample(), 1'b0);
      end
    end
    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule